// File: doc/BRIEF.md
# Prescaled Tick Counter with Capture

This block is a free-running up-counter for timing and time-stamping. It advances on a tick that comes from one of two sources. The first is a power-of-two divider driven by the bus clock. The second is an external clock pin, which is resynchronized to the bus clock and edge-detected. A small control register holds three things: a halt flag, a 3-bit source select, and a one-shot clear command. The clear command zeroes both the counter and the divider.

A single capture channel watches a second pin. On each synchronized rising edge of that pin, the channel copies the running count into a capture register and raises a sticky flag. Software clears the flag by writing a 1 to it. While the counter is halted, capture events are dropped.

Software reaches the block through a plain register port. A write takes effect on the clock edge where `bus_wr` is high. Read data is a combinational decode of `bus_addr`. The address map is: 0 = control, 1 = count, 2 = captured value, 3 = capture flag. The control word has these fields:
- bits [2:0]: source select
- bit 3: clear command
- bit 4: halt

Top module: `tick_timer`

## Requirements
- R1: After reset, the control word reads 0x0010 (halt = 1, select = 000), and the count, captured value and capture flag are all 0. The count stays at 0 while halted.
- R2: While halt is 1, the count holds its value. Writing halt back to 0 resumes counting from the held value. The write edge that sets halt is the last edge on which the count can still step.
- R3: Writing control bit 3 as 1 zeroes the count and the divider on that write edge. It leaves the captured value and the capture flag untouched. Bit 3 always reads back as 0.
- R4: A single control write with halt = 1 and clear = 1 leaves the count at 0x0000, and it stays there.
- R5: Select codes 0 to 6 step the count once every 2^code bus cycles. Right after a clear, the count reaches N/2^code after N cycles, where N is a multiple of 2^code.
- R6: Select code 7 steps the count once per rising edge on `ext_clk`, after a synchronizer, regardless of how long the pin stays high. With no pin edges, the count does not move.
- R7: The count is CNT_W bits wide and wraps from all ones to 0.
- R8: A synchronized rising edge on `cap_in` while running copies the count into the captured value and sets the flag. The flag reads at address 3, bit 0.
- R9: While halt is 1, edges on `cap_in` change neither the flag nor the captured value.
- R10: The flag clears only when a 1 is written to address 3, bit 0. Writing 0 has no effect.
- R11: The select field is read/write and returns the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 5 | Write data (control or flag) |
| bus_rdata | output | CNT_W | Read data for bus_addr |
| ext_clk | input | 1 | External count clock pin |
| cap_in | input | 1 | Capture trigger pin |
| count_o | output | CNT_W | Current count |
| cap_flag_o | output | 1 | Capture flag |

## Verification
The bench measures each divider rate from a fresh clear. A divider that ignores the clear, or taps the wrong bit, leaves an off-by-one or a doubled count. It also times the first tick after a clear with the divide-by-64 source. A clear that spared the divider would move that tick away from cycle 33.

Other corner cases are checked as well:
- A combined halt-and-clear write must give 0. A design that applied halt one edge late would leave a count of 1.
- A long external pulse must count once. A level-sensitive design would run away on it.
- A capture while halted must be dropped, and a clear must not touch the capture state.

Wrap at all ones is checked exactly, on the cycle where it happens.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   localparam int SEL_W    = 3;
   localparam int CLR_BIT  = 3;
   localparam int HALT_BIT = 4;
   localparam int WR_W     = HALT_BIT + 1;
   localparam int FLAG_BIT = 0;

   typedef enum logic [1:0] {
      ADDR_CTRL  = 2'd0,
      ADDR_COUNT = 2'd1,
      ADDR_CAPT  = 2'd2,
      ADDR_FLAG  = 2'd3
   } tt_addr_e;
endpackage

// File: rtl/tt_edge_sync.sv
module tt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din};
   end

   // sh_q[STAGES-1] is the last synchronizer flop, sh_q[STAGES] its history
   assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
   parameter int SEL_W = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   output logic [(2**SEL_W)-2:0]   taps
);
   localparam int TAP_N = (2**SEL_W) - 1;
   localparam int DIV_W = TAP_N - 1;

   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   div_q <= '0;
      else if (clr) div_q <= '0;
      else          div_q <= div_q + 1'b1;
   end

   // tap k pulses in the cycle where divider bit k-1 has just risen
   for (genvar k = 0; k < TAP_N; k++) begin : g_tap
      if (k == 0) begin : g_full
         assign taps[k] = 1'b1;
      end else if (k == 1) begin : g_half
         assign taps[k] = div_q[0];
      end else begin : g_div
         assign taps[k] = div_q[k-1] & ~(|div_q[k-2:0]);
      end
   end
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (en)  count <= count + 1'b1;
   end
endmodule

// File: rtl/tt_capture.sv
module tt_capture #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         trig,
   input  logic         block,
   input  logic         flag_clr,
   input  logic [W-1:0] count,
   output logic [W-1:0] cap_val,
   output logic         flag
);
   logic take;
   assign take = trig & ~block;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_val <= '0;
         flag    <= 1'b0;
      end else begin
         if (take) cap_val <= count;
         if (take)          flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
      end
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [1:0]          bus_addr,
   input  logic [WR_W-1:0]     bus_wdata,
   output logic [CNT_W-1:0]    bus_rdata,
   input  logic                ext_clk,
   input  logic                cap_in,
   output logic [CNT_W-1:0]    count_o,
   output logic                cap_flag_o
);
   localparam int SRC_N = 2**SEL_W;

   if (CNT_W < WR_W) begin : g_bad_width
      $error("tick_timer: CNT_W must hold the control word");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tick_timer: SYNC_STAGES must be at least 2");
   end

   tt_addr_e         addr;
   logic             halt_q;
   logic [SEL_W-1:0] sel_q;
   logic             ctrl_wr, clr_pulse, flag_clr;
   logic             ext_rise, cap_rise, tick;
   logic [SRC_N-2:0] taps;
   logic [SRC_N-1:0] sources;
   logic [CNT_W-1:0] count, cap_val;
   logic             cap_flag;

   assign addr      = tt_addr_e'(bus_addr);
   assign ctrl_wr   = bus_wr && (addr == ADDR_CTRL);
   assign clr_pulse = ctrl_wr && bus_wdata[CLR_BIT];
   assign flag_clr  = bus_wr && (addr == ADDR_FLAG) && bus_wdata[FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b1;
         sel_q  <= '0;
      end else if (ctrl_wr) begin
         halt_q <= bus_wdata[HALT_BIT];
         sel_q  <= bus_wdata[SEL_W-1:0];
      end
   end

   tt_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_clk), .rise(ext_rise)
   );

   tt_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
      .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(cap_rise)
   );

   tt_prescaler #(.SEL_W(SEL_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .taps(taps)
   );

   // the all-ones select code picks the external pin
   assign sources = {ext_rise, taps};
   assign tick    = sources[sel_q];

   tt_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_pulse),
      .en(tick & ~halt_q), .count(count)
   );

   tt_capture #(.W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .trig(cap_rise), .block(halt_q),
      .flag_clr(flag_clr), .count(count), .cap_val(cap_val), .flag(cap_flag)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (addr)
         ADDR_CTRL: begin
            bus_rdata[SEL_W-1:0] = sel_q;
            bus_rdata[HALT_BIT]  = halt_q;
         end
         ADDR_COUNT: bus_rdata = count;
         ADDR_CAPT:  bus_rdata = cap_val;
         ADDR_FLAG:  bus_rdata[FLAG_BIT] = cap_flag;
      endcase
   end

   assign count_o    = count;
   assign cap_flag_o = cap_flag;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         halt_q,
   input logic         clr_pulse,
   input logic         flag_clr,
   input logic [W-1:0] count,
   input logic [W-1:0] cap_val,
   input logic         cap_flag
);
   // R2: halted and not cleared -> count frozen
   a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !clr_pulse) |=> $stable(count));

   // R3 / R4: a clear command leaves zero
   a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> (count == '0));

   // R7: while running the count moves by at most one, wrapping
   a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_q && !clr_pulse) |=> ($stable(count) || (count == W'($past(count) + 1'b1))));

   // R8: a new capture holds the count of the capturing cycle
   a_r8_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_flag) |-> (cap_val == $past(count)));

   // R9: no capture while halted
   a_r9_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !cap_flag) |=> (!cap_flag && $stable(cap_val)));

   // R10: flag is sticky until a clear write
   a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flag && !flag_clr) |=> cap_flag);
endmodule

bind tick_timer tick_timer_chk #(.W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .halt_q(halt_q), .clr_pulse(clr_pulse),
   .flag_clr(flag_clr), .count(count), .cap_val(cap_val), .cap_flag(cap_flag)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [1:0]    bus_addr = 2'd0;
   logic [4:0]    bus_wdata = '0;
   logic [W-1:0]  bus_rdata;
   logic          ext_clk = 1'b0;
   logic          cap_in = 1'b0;
   logic [W-1:0]  count_o;
   logic          cap_flag_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   tick_timer u_tick_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
      .cap_in(cap_in), .count_o(count_o), .cap_flag_o(cap_flag_o)
   );

   // {select, cycles, expected count}
   localparam logic [26:0] VECS [0:6] = '{
      {3'd0, 12'd128, 12'd128},
      {3'd1, 12'd128, 12'd64},
      {3'd2, 12'd128, 12'd32},
      {3'd3, 12'd128, 12'd16},
      {3'd4, 12'd128, 12'd8},
      {3'd5, 12'd128, 12'd4},
      {3'd6, 12'd256, 12'd4}
   };

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [4:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [1:0] a, input logic [W-1:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ext_pulse(input int hi, input int lo);
      ext_clk = 1'b1;
      idle(hi);
      ext_clk = 1'b0;
      idle(lo);
   endtask

   task automatic cap_pulse;
      cap_in = 1'b1;
      idle(4);
      cap_in = 1'b0;
      idle(5);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd_check("R1 ctrl", 2'd0, 16'h0010);
      rd_check("R1 count", 2'd1, 16'h0000);
      rd_check("R1 capt", 2'd2, 16'h0000);
      rd_check("R1 flag", 2'd3, 16'h0000);
      idle(20);
      check("R1 halted after reset", count_o, 16'h0000);

      // R11 select read/write, R3 clear bit reads 0
      wr(2'd0, 5'h15);
      rd_check("R11 select readback", 2'd0, 16'h0015);
      wr(2'd0, 5'h1D);
      rd_check("R3 clear reads 0", 2'd0, 16'h0015);

      // R5 divider rates from a fresh clear
      for (int i = 0; i < 7; i++) begin
         wr(2'd0, 5'h08 | {2'b00, VECS[i][26:24]});
         idle(int'(VECS[i][23:12]));
         check($sformatf("R5 rate code %0d", i), count_o, {4'h0, VECS[i][11:0]});
      end

      // R2 halt and resume
      wr(2'd0, 5'h08);
      idle(20);
      wr(2'd0, 5'h10);
      check("R2 halt edge", count_o, 16'd21);
      idle(10);
      check("R2 held", count_o, 16'd21);
      wr(2'd0, 5'h00);
      check("R2 resume edge", count_o, 16'd21);
      idle(5);
      check("R2 resumed", count_o, 16'd26);

      // R4 halt and clear together
      wr(2'd0, 5'h18);
      check("R4 zero", count_o, 16'h0000);
      idle(10);
      check("R4 stays zero", count_o, 16'h0000);
      rd_check("R4 ctrl", 2'd0, 16'h0010);

      // R3 divider cleared too: first /64 tick lands 33 cycles after clear
      wr(2'd0, 5'h06);
      idle(13);
      wr(2'd0, 5'h0E);
      idle(32);
      check("R3 divider phase before", count_o, 16'd0);
      idle(1);
      check("R3 divider phase tick", count_o, 16'd1);

      // R7 wrap
      wr(2'd0, 5'h08);
      idle(65535);
      check("R7 all ones", count_o, 16'hFFFF);
      idle(1);
      check("R7 wrap", count_o, 16'h0000);

      // R6 external clock
      wr(2'd0, 5'h0F);
      for (int p = 0; p < 5; p++) ext_pulse(3, 3);
      idle(5);
      check("R6 five edges", count_o, 16'd5);
      ext_pulse(12, 5);
      check("R6 long pulse once", count_o, 16'd6);
      idle(20);
      check("R6 no edges no steps", count_o, 16'd6);

      // R8 capture
      cap_pulse();
      rd_check("R8 flag set", 2'd3, 16'h0001);
      rd_check("R8 captured", 2'd2, 16'd6);

      // R10 writing 0 does nothing
      wr(2'd3, 5'h00);
      rd_check("R10 write 0 keeps flag", 2'd3, 16'h0001);

      // R3 clear leaves capture state alone
      wr(2'd0, 5'h0F);
      check("R3 count cleared", count_o, 16'd0);
      rd_check("R3 capt kept", 2'd2, 16'd6);
      rd_check("R3 flag kept", 2'd3, 16'h0001);

      // R10 write 1 clears
      wr(2'd3, 5'h01);
      rd_check("R10 flag cleared", 2'd3, 16'h0000);

      ext_pulse(3, 3);
      ext_pulse(3, 6);
      cap_pulse();
      rd_check("R8 second capture", 2'd2, 16'd2);
      wr(2'd3, 5'h01);

      // R9 halted: captures and ext edges ignored
      wr(2'd0, 5'h17);
      ext_pulse(3, 6);
      check("R2 ext halted", count_o, 16'd2);
      ext_pulse(3, 3);
      cap_pulse();
      rd_check("R9 flag stays 0", 2'd3, 16'h0000);
      ext_pulse(3, 3);
      rd_check("R9 capt kept", 2'd2, 16'd2);
      wr(2'd0, 5'h07);
      ext_pulse(3, 6);
      check("R2 ext resume", count_o, 16'd3);

      finish_run();
   end
endmodule